// File: doc/BRIEF.md
# Receive Descriptor Write-Back Engine

This block moves received frames from a word-wide receive stream into memory buffers described by a linked list of descriptors. Each descriptor occupies four 32-bit words. Before it uses a descriptor, the engine reads it and checks whether the DMA owns it. It fills that descriptor's buffer up to the stated size. A frame that does not fit continues in the buffers of the following descriptors. When the engine closes a descriptor, it writes back a status word that hands ownership back to software. That word marks the buffer that holds the start of the frame and the buffer that holds its end. The buffer that holds the end also carries the total frame length.

After each frame ends, the engine raises a one-cycle receive interrupt pulse, unless that descriptor asks for the interrupt to be suppressed. The engine may find a descriptor that it does not own, either at the start of a frame or in the middle of one. In that case it stops, pulses a buffer-unavailable flag and keeps the descriptor pointer it had reached. A strobe on the poll-demand input makes it read that same descriptor again.

The receive stream uses valid/ready handshaking. The source holds `s_data`, `s_sof` and `s_eof` stable while `s_valid` is high and `s_ready` is low. A word is transferred in a cycle in which both are high. The engine raises `s_ready` only while it is filling a buffer and the memory port accepts a write in that same cycle. Memory transfers complete in any cycle in which `mem_req` and `mem_ready` are both high. Read data is taken from `mem_rdata` in that cycle.

Top module: `rxdesc_engine`

## Requirements
- R1: A descriptor at address P has four words, with fields at fixed positions:
  - P+0 holds the status word, with ownership in bit 31 (1 means the DMA owns it).
  - P+4 holds the interrupt-disable bit in bit 31 and the buffer size in bytes in bits 12:0. The size is a non-zero multiple of 4.
  - P+8 holds the buffer address.
  - P+12 holds the address of the next descriptor.
  
  After reset the list starts at parameter `LIST_BASE`.
- R2: Each accepted stream word is written to the buffer address plus the byte offset of that word within the buffer. The first word goes at offset 0, and each following word 4 bytes higher. `s_ready` is never high while `mem_ready` is low.
- R3: The written-back status of the descriptor whose buffer received the start-of-frame word has bit 9 (first segment) set. The status of every other descriptor has bit 9 clear.
- R4: The status of the descriptor whose buffer received the end-of-frame word has bit 8 (last segment) set. A frame that fits in one buffer has bits 9 and 8 both set in one descriptor.
- R5: When a buffer fills before the end of the frame, the engine reads the ownership word of the next descriptor, then closes the full one, then continues the frame in the next buffer. No write lands at or beyond the buffer size.
- R6: Closing a descriptor writes its status word with bit 31 clear.
- R7: Status bits 29:16 hold the frame length in bytes (4 per word) in the descriptor with the last-segment bit set, and are zero in the other descriptors of the frame.
- R8: `rx_irq` pulses for exactly one cycle after a last-segment descriptor whose interrupt-disable bit is 0 is closed. It does not pulse when that bit is 1, or when the closed descriptor is not the last segment.
- R9: Reading an ownership bit of 0 makes `suspended` go high with a one-cycle `rx_unavail` pulse in the same cycle. While suspended, no stream word is accepted and no memory request is made.
- R10: A `poll` strobe while suspended makes the engine re-read the descriptor at the pointer it stopped on. If that descriptor is owned, reception resumes there. If it is not, a new `rx_unavail` pulse follows and the engine stays suspended.
- R11: After reset, `s_ready`, `mem_req`, `rx_irq`, `rx_unavail` and `suspended` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| s_valid | input | 1 | Stream word valid |
| s_ready | output | 1 | Stream word accepted |
| s_data | input | 32 | Stream data word |
| s_sof | input | 1 | Word is the first of a frame |
| s_eof | input | 1 | Word is the last of a frame |
| mem_req | output | 1 | Memory transfer request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 32 | Byte address |
| mem_wdata | output | 32 | Write data |
| mem_ready | input | 1 | Memory accepts the transfer this cycle |
| mem_rdata | input | 32 | Read data, valid with mem_ready |
| poll | input | 1 | Poll-demand strobe |
| rx_irq | output | 1 | Receive-complete pulse |
| rx_unavail | output | 1 | Descriptor-unavailable pulse |
| suspended | output | 1 | Engine is suspended |

## Verification
The tests cover several frame shapes:
- A short frame in a large buffer checks that the first and last flags share one descriptor.
- A frame spread over three small buffers checks that the middle descriptor carries neither flag and that the length appears only on the last.
- A frame with the interrupt suppressed checks the status write-back separately from the interrupt.

Two stops cover suspension. One stops before the frame starts, including a poll while the descriptor is still not owned. The other stops in mid-frame, which tells apart the close of the full buffer from the resume point. A run with an intermittently stalling memory shows that data and status do not depend on when the handshake completes.

// File: rtl/rxd_pkg.sv
package rxd_pkg;
  localparam int OWN_BIT = 31;
  localparam int ICD_BIT = 31;
  localparam int FS_BIT  = 9;
  localparam int LS_BIT  = 8;
  localparam int LEN_LSB = 16;

  typedef enum logic [2:0] {
    ST_IDLE, ST_RD_OWN, ST_RD_CTL, ST_RD_BUF,
    ST_RD_NXT, ST_DATA, ST_CLOSE, ST_SUSP
  } rxd_state_t;
endpackage

// File: rtl/rxd_buf_track.sv
module rxd_buf_track #(
  parameter int SIZE_W = 13,
  parameter int LEN_W  = 14
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              buf_start,
  input  logic              step,
  input  logic              step_sof,
  input  logic [SIZE_W-1:0] size,
  output logic [SIZE_W-1:0] off,
  output logic [LEN_W-1:0]  len_next,
  output logic              last_slot
);
  logic [LEN_W-1:0] frm_len;

  assign len_next  = step_sof ? LEN_W'(4) : frm_len + LEN_W'(4);
  assign last_slot = ({1'b0, off} + (SIZE_W+1)'(4)) >= {1'b0, size};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      off     <= '0;
      frm_len <= '0;
    end else begin
      if (buf_start) off <= '0;
      else if (step) off <= off + SIZE_W'(4);
      if (step) frm_len <= len_next;
    end
  end

  // R5
  buf_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    step |-> (off < size));
endmodule

// File: rtl/rxd_wb_word.sv
module rxd_wb_word #(
  parameter int LEN_W = 14
) (
  input  logic             first,
  input  logic             last,
  input  logic [LEN_W-1:0] len,
  output logic [31:0]      word
);
  import rxd_pkg::*;
  always_comb begin
    word = '0;
    word[LEN_LSB +: LEN_W] = len;
    word[FS_BIT] = first;
    word[LS_BIT] = last;
    word[OWN_BIT] = 1'b0;
  end
endmodule

// File: rtl/rxdesc_engine.sv
module rxdesc_engine #(
  parameter int          AW        = 32,
  parameter int          SIZE_W    = 13,
  parameter int          LEN_W     = 14,
  parameter logic [31:0] LIST_BASE = 32'h0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          s_valid,
  output logic          s_ready,
  input  logic [31:0]   s_data,
  input  logic          s_sof,
  input  logic          s_eof,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [31:0]   mem_wdata,
  input  logic          mem_ready,
  input  logic [31:0]   mem_rdata,
  input  logic          poll,
  output logic          rx_irq,
  output logic          rx_unavail,
  output logic          suspended
);
  import rxd_pkg::*;

  localparam int PADW = AW - SIZE_W;

  rxd_state_t        st;
  logic [AW-1:0]     cur_ptr, next_ptr, buf_addr, close_addr;
  logic [SIZE_W-1:0] size;
  logic              icd, fseg, close_pend, nxt_ok;
  logic              cl_first, cl_last, cl_icd;
  logic [LEN_W-1:0]  cl_len;
  logic [SIZE_W-1:0] off;
  logic [LEN_W-1:0]  len_next;
  logic              last_slot, fire, acc, buf_start;
  logic [31:0]       close_word;

  assign fire      = mem_req && mem_ready;
  assign acc       = (st == ST_DATA) && s_valid && mem_ready;
  assign buf_start = (st == ST_RD_NXT) && fire;
  assign suspended = (st == ST_SUSP);

  rxd_buf_track #(.SIZE_W(SIZE_W), .LEN_W(LEN_W)) u_track (
    .clk(clk), .rst_n(rst_n), .buf_start(buf_start), .step(acc),
    .step_sof(s_sof), .size(size), .off(off), .len_next(len_next),
    .last_slot(last_slot)
  );

  rxd_wb_word #(.LEN_W(LEN_W)) u_wb (
    .first(cl_first), .last(cl_last), .len(cl_len), .word(close_word)
  );

  always_comb begin
    mem_req   = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = cur_ptr;
    mem_wdata = '0;
    s_ready   = 1'b0;
    unique case (st)
      ST_RD_OWN: mem_req = 1'b1;
      ST_RD_CTL: begin mem_req = 1'b1; mem_addr = cur_ptr + AW'(4);  end
      ST_RD_BUF: begin mem_req = 1'b1; mem_addr = cur_ptr + AW'(8);  end
      ST_RD_NXT: begin mem_req = 1'b1; mem_addr = cur_ptr + AW'(12); end
      ST_DATA: begin
        mem_req   = s_valid;
        mem_we    = 1'b1;
        mem_addr  = buf_addr + {{PADW{1'b0}}, off};
        mem_wdata = s_data;
        s_ready   = mem_ready;
      end
      ST_CLOSE: begin
        mem_req   = 1'b1;
        mem_we    = 1'b1;
        mem_addr  = close_addr;
        mem_wdata = close_word;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= ST_IDLE;
      cur_ptr <= LIST_BASE[AW-1:0];
      next_ptr <= '0; buf_addr <= '0; close_addr <= '0;
      size <= '0; icd <= 1'b0; fseg <= 1'b0;
      close_pend <= 1'b0; nxt_ok <= 1'b0;
      cl_first <= 1'b0; cl_last <= 1'b0; cl_icd <= 1'b0; cl_len <= '0;
      rx_irq <= 1'b0; rx_unavail <= 1'b0;
    end else begin
      rx_irq     <= 1'b0;
      rx_unavail <= 1'b0;
      unique case (st)
        ST_IDLE: if (s_valid) st <= ST_RD_OWN;
        ST_RD_OWN: if (fire) begin
          if (close_pend) begin
            nxt_ok <= mem_rdata[OWN_BIT];
            st     <= ST_CLOSE;
          end else if (mem_rdata[OWN_BIT]) begin
            st <= ST_RD_CTL;
          end else begin
            st         <= ST_SUSP;
            rx_unavail <= 1'b1;
          end
        end
        ST_RD_CTL: if (fire) begin
          icd  <= mem_rdata[ICD_BIT];
          size <= mem_rdata[SIZE_W-1:0];
          st   <= ST_RD_BUF;
        end
        ST_RD_BUF: if (fire) begin
          buf_addr <= mem_rdata[AW-1:0];
          st       <= ST_RD_NXT;
        end
        ST_RD_NXT: if (fire) begin
          next_ptr <= mem_rdata[AW-1:0];
          fseg     <= 1'b0;
          st       <= ST_DATA;
        end
        ST_DATA: if (acc) begin
          if (s_sof) fseg <= 1'b1;
          if (s_eof || last_slot) begin
            cl_first   <= fseg || s_sof;
            cl_last    <= s_eof;
            cl_len     <= s_eof ? len_next : '0;
            cl_icd     <= icd;
            close_addr <= cur_ptr;
            cur_ptr    <= next_ptr;
            close_pend <= !s_eof;
            st         <= s_eof ? ST_CLOSE : ST_RD_OWN;
          end
        end
        ST_CLOSE: if (fire) begin
          close_pend <= 1'b0;
          rx_irq     <= cl_last && !cl_icd;
          if (cl_last) st <= ST_IDLE;
          else if (nxt_ok) st <= ST_RD_CTL;
          else begin
            st         <= ST_SUSP;
            rx_unavail <= 1'b1;
          end
        end
        ST_SUSP: if (poll) st <= ST_RD_OWN;
        default: st <= ST_IDLE;
      endcase
    end
  end

  // R2
  accept_mem_chk: assert property (@(posedge clk) disable iff (!rst_n)
    s_ready |-> mem_ready);
  // R8
  irq_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_irq |=> !rx_irq);
  // R9
  susp_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(suspended) |-> rx_unavail);
  // R9
  susp_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    suspended |-> (!mem_req && !s_ready));
endmodule

// File: tb/rxdesc_engine_test.sv
module rxdesc_engine_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic s_valid = 1'b0, s_sof = 1'b0, s_eof = 1'b0, poll = 1'b0, stall = 1'b0;
  logic [31:0] s_data = '0;
  logic s_ready, mem_req, mem_we, mem_ready, rx_irq, rx_unavail, suspended;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic [31:0] mem [0:255];
  logic bw_en = 1'b0;
  logic [7:0] bw_idx = '0;
  logic [31:0] bw_data = '0;
  int n_chk = 0, n_fail = 0, irq_cnt = 0, ua_cnt = 0, nd = 0;

  always #5 clk = ~clk;

  rxdesc_engine uut (
    .clk(clk), .rst_n(rst_n), .s_valid(s_valid), .s_ready(s_ready),
    .s_data(s_data), .s_sof(s_sof), .s_eof(s_eof), .mem_req(mem_req),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ready(mem_ready), .mem_rdata(mem_rdata), .poll(poll),
    .rx_irq(rx_irq), .rx_unavail(rx_unavail), .suspended(suspended)
  );

  assign mem_ready = !stall;
  assign mem_rdata = mem[mem_addr[9:2]];

  always @(posedge clk) begin
    if (bw_en) mem[bw_idx] <= bw_data;
    else if (mem_req && mem_ready && mem_we) mem[mem_addr[9:2]] <= mem_wdata;
    if (rst_n && rx_irq) irq_cnt <= irq_cnt + 1;
    if (rst_n && rx_unavail) ua_cnt <= ua_cnt + 1;
  end

  function automatic int dsc(int i); return 16 * (i % 4); endfunction
  function automatic int bufa(int i); return 32'h100 + 64 * (i % 4); endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(int byte_addr, logic [31:0] d);
    @(negedge clk);
    bw_en = 1'b1; bw_idx = byte_addr[9:2]; bw_data = d;
    @(negedge clk);
    bw_en = 1'b0;
  endtask

  task automatic arm(int i, bit own, bit icd, int size);
    wr(dsc(i),      {own, 31'h0});
    wr(dsc(i) + 4,  {icd, 18'h0, size[12:0]});
    wr(dsc(i) + 8,  bufa(i));
    wr(dsc(i) + 12, dsc(i + 1));
    for (int k = 0; k < 16; k++) wr(bufa(i) + 4 * k, 32'h0);
  endtask

  task automatic send(int n, logic [31:0] base);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      s_valid = 1'b1; s_data = base + k; s_sof = (k == 0); s_eof = (k == n - 1);
      #1;
      while (!s_ready) begin @(negedge clk); #1; end
    end
    @(negedge clk);
    s_valid = 1'b0; s_sof = 1'b0; s_eof = 1'b0;
  endtask

  task automatic settle(); repeat (12) @(negedge clk); endtask

  task automatic pulse_poll();
    @(negedge clk); poll = 1'b1;
    @(negedge clk); poll = 1'b0;
  endtask

  task automatic t_reset();
    check("R11 s_ready", s_ready, 0);
    check("R11 mem_req", mem_req, 0);
    check("R11 rx_irq", rx_irq, 0);
    check("R11 rx_unavail", rx_unavail, 0);
    check("R11 suspended", suspended, 0);
  endtask

  task automatic t_single();
    int i0 = irq_cnt;
    arm(nd, 1, 0, 64);
    send(3, 32'hA000);
    settle();
    // R1 R3 R4 R6 R7: own clear, first+last, length 12
    check("R4 single status", mem[dsc(nd) / 4], 32'h000C_0300);
    check("R2 word0", mem[bufa(nd) / 4], 32'hA000);
    check("R2 word2", mem[bufa(nd) / 4 + 2], 32'hA002);
    check("R2 no spill", mem[bufa(nd) / 4 + 3], 32'h0);
    check("R8 irq", irq_cnt - i0, 1);
    nd = (nd + 1) % 4;
  endtask

  task automatic t_split();
    int i0 = irq_cnt;
    arm(nd, 1, 0, 8); arm(nd + 1, 1, 0, 8); arm(nd + 2, 1, 0, 8);
    send(5, 32'hB000);
    settle();
    check("R3 first seg", mem[dsc(nd) / 4], 32'h0000_0200);
    check("R5 middle seg", mem[dsc(nd + 1) / 4], 32'h0);
    check("R7 last seg len", mem[dsc(nd + 2) / 4], 32'h0014_0100);
    check("R5 bound", mem[bufa(nd) / 4 + 2], 32'h0);
    check("R5 next buf", mem[bufa(nd + 1) / 4], 32'hB002);
    check("R2 tail", mem[bufa(nd + 2) / 4], 32'hB004);
    check("R8 one irq", irq_cnt - i0, 1);
    nd = (nd + 3) % 4;
  endtask

  task automatic t_icd();
    int i0 = irq_cnt;
    arm(nd, 1, 1, 64);
    send(2, 32'hC000);
    settle();
    check("R6 suppressed status", mem[dsc(nd) / 4], 32'h0008_0300);
    check("R8 no irq", irq_cnt - i0, 0);
    nd = (nd + 1) % 4;
  endtask

  task automatic t_unavail();
    int u0 = ua_cnt;
    arm(nd, 0, 0, 64);
    fork send(2, 32'hD000); join_none
    settle();
    check("R9 suspended", suspended, 1);
    check("R9 unavail pulse", ua_cnt - u0, 1);
    check("R9 no data", mem[bufa(nd) / 4], 32'h0);
    pulse_poll();
    settle();
    check("R10 still unowned", ua_cnt - u0, 2);
    check("R10 still suspended", suspended, 1);
    wr(dsc(nd), 32'h8000_0000);
    pulse_poll();
    settle();
    check("R10 resumed", suspended, 0);
    check("R10 same desc", mem[dsc(nd) / 4], 32'h0008_0300);
    check("R10 data", mem[bufa(nd) / 4 + 1], 32'hD001);
    nd = (nd + 1) % 4;
  endtask

  task automatic t_midframe();
    int u0 = ua_cnt;
    arm(nd, 1, 0, 8); arm(nd + 1, 0, 0, 64);
    fork send(4, 32'hE000); join_none
    settle();
    check("R9 mid suspended", suspended, 1);
    check("R5 closed before stop", mem[dsc(nd) / 4], 32'h0000_0200);
    check("R9 mid unavail", ua_cnt - u0, 1);
    wr(dsc(nd + 1), 32'h8000_0000);
    pulse_poll();
    settle();
    check("R7 resumed last", mem[dsc(nd + 1) / 4], 32'h0010_0100);
    check("R10 resumed data", mem[bufa(nd + 1) / 4], 32'hE002);
    nd = (nd + 2) % 4;
  endtask

  task automatic t_stall();
    arm(nd, 1, 0, 64);
    fork
      send(4, 32'hF000);
      begin
        for (int k = 0; k < 14; k++) begin @(negedge clk); stall = (k % 3 != 2); end
        @(negedge clk); stall = 1'b0;
      end
    join
    settle();
    check("R2 stall status", mem[dsc(nd) / 4], 32'h0010_0300);
    check("R2 stall data", mem[bufa(nd) / 4 + 3], 32'hF003);
    nd = (nd + 1) % 4;
  endtask

  task automatic finish_up();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual running expected done");
    finish_up();
  end

  initial begin
    for (int k = 0; k < 256; k++) mem[k] = 32'h0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_single();
    t_split();
    t_icd();
    t_unavail();
    t_midframe();
    t_stall();
    finish_up();
  end
endmodule